// File: doc/BRIEF.md
# Request-Gated Byte-Strobe Serial Transmitter

This block is the sending end of a byte-oriented serial link whose clock it shares with a remote consumer. Parallel bytes arrive on a valid/ready input. A byte goes out only when the remote consumer has its request line high. The block then marks the first bit with a one-cycle byte strobe and shifts the byte out most significant bit first, one bit per clock. The request is looked at again at the edge that closes the last bit, so a consumer that keeps asking receives bytes with no gap between them. A consumer that stops asking leaves the line idle with no strobe.

A frame starts when the host pulses a frame-start input together with a byte budget. The block sends a one-cycle frame pulse to the consumer and then accepts no more than the budgeted number of bytes. A request that arrives with no frame open, or after the budget is used up, is refused and raises a sticky protocol-violation flag. The clock input is the shared serial clock, and every output changes only on its rising edge.

Top module: `txb_serial_tx`

## Requirements
- R1: When `frame_start_i` is high at a rising edge, `frm_o` is high for the following cycle, the sent-byte count returns to zero, `viol_o` clears, and `frame_len_i` is latched as the frame budget (limited to MAX_BYTES).
- R2: At an edge where the block is listening, `req_i` is high and the frame has budget left, `in_ready_o` is high. If `in_valid_i` is also high, the byte is taken, and in the next cycle `bs_o` is 1 and `sd_o` carries bit 7.
- R3: In the BYTE_W-1 cycles after the strobe cycle, `sd_o` carries bits 6 down to 0 in that order and `bs_o` stays 0.
- R4: The block listens again at the edge that ends the bit-0 cycle. If the request is granted there, the next strobe comes in the very next cycle, so continuous requests give strobes exactly BYTE_W cycles apart.
- R5: If `req_i` is low, or no byte is offered, at a listening edge, no strobe follows and the block listens again at every later edge. The strobe comes one cycle after the first granting edge, so one cycle of waiting gives a spacing of BYTE_W+1 cycles.
- R6: From the strobe cycle until the bit-0 cycle, `req_i` has no effect. `in_ready_o` stays 0, and lowering the request does not shorten the byte in flight.
- R7: A frame carries at most its latched budget of bytes, and a budget of 0 carries none. With no frame opened since reset, or with the budget used up, `in_ready_o` is 0 and no strobe occurs.
- R8: While idle, `bs_o` is 0 and `sd_o` holds the last bit it drove.
- R9: `viol_o` becomes 1 after a listening edge at which `req_i` is high and no budget is left (including before the first frame). It stays 1 until the next frame start.
- R10: After reset, `bs_o`, `frm_o`, `viol_o`, `sd_o` and `in_ready_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared serial clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start_i | input | 1 | Opens a new frame at this edge |
| frame_len_i | input | CNT_W | Byte budget of the frame being opened |
| in_data_i | input | BYTE_W | Byte offered for sending |
| in_valid_i | input | 1 | Offered byte is valid |
| in_ready_o | output | 1 | Byte would be taken at this edge |
| req_i | input | 1 | Data request from the remote consumer |
| frm_o | output | 1 | One-cycle frame pulse |
| bs_o | output | 1 | Byte strobe, high during bit 7 |
| sd_o | output | 1 | Serial data, MSB first |
| viol_o | output | 1 | Sticky flag for a request that was refused |

## Verification
The bench builds the block with BYTE_W = 8 and MAX_BYTES = 15. With a 4-bit budget field, frames of 4, 2 and 0 bytes run out their budgets within a few dozen cycles, so the exhausted-budget refusal and the violation flag are reached quickly. With 8-bit bytes, the strobe-to-strobe spacing can be checked at exactly 8 cycles for back-to-back bytes and at 9 cycles after a single missed request, against the consumer's request timing. A scoreboard compares every strobed byte bit by bit with the order in which the bytes were offered.

// File: rtl/txb_pkg.sv
// Shared definitions for the request-gated serial transmitter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package txb_pkg;
    // Phase of the shift engine
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_SHIFT = 1'b1
    } txb_phase_e;

    // Counter width able to hold values 0..max_val
    function automatic int cnt_bits(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction
endpackage

// File: rtl/txb_frame_budget.sv
// Frame bookkeeping: opens a frame on frame_start_i, latches the byte
// budget (limited to MAX_BYTES), counts bytes taken, emits the frame
// pulse and keeps the sticky violation flag.
// Assumes take_i is only high when room_o is high.
module txb_frame_budget #(
    parameter int MAX_BYTES = 255,
    parameter int CNT_W     = txb_pkg::cnt_bits(MAX_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic [CNT_W-1:0] frame_len_i,
    input  logic             take_i,
    input  logic             listen_i,
    input  logic             req_i,
    output logic             room_o,
    output logic             frm_o,
    output logic             viol_o
);
    localparam logic [CNT_W-1:0] LenCap = CNT_W'(MAX_BYTES);

    logic             open_q;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] sent_q;
    logic [CNT_W-1:0] len_clamped;

    // Limit the requested budget to the configured maximum
    always_comb begin
        len_clamped = (frame_len_i > LenCap) ? LenCap : frame_len_i;
    end

    // Budget left in the current frame
    always_comb begin
        room_o = open_q && (sent_q < len_q);
    end

    // Frame open state, budget and sent-byte count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            len_q  <= '0;
            sent_q <= '0;
        end else if (frame_start_i) begin
            open_q <= 1'b1;
            len_q  <= len_clamped;
            sent_q <= '0;
        end else if (take_i) begin
            sent_q <= sent_q + 1'b1;
        end
    end

    // One-cycle frame pulse toward the consumer
    always_ff @(posedge clk) begin
        if (!rst_n) frm_o <= 1'b0;
        else        frm_o <= frame_start_i;
    end

    // Sticky flag for requests arriving without budget
    always_ff @(posedge clk) begin
        if (!rst_n)                              viol_o <= 1'b0;
        else if (frame_start_i)                  viol_o <= 1'b0;
        else if (listen_i && req_i && !room_o)   viol_o <= 1'b1;
    end
endmodule

// File: rtl/txb_req_gate.sv
// Decides at each edge whether a byte is taken: the shifter must be
// listening (idle or on its last bit), the consumer must request, the
// frame must have budget, and the producer must offer a byte.
// Pure combinational; assumes registered inputs from its neighbours.
module txb_req_gate (
    input  logic active_i,
    input  logic last_i,
    input  logic req_i,
    input  logic room_i,
    input  logic in_valid_i,
    output logic listen_o,
    output logic ready_o,
    output logic take_o
);
    // Listening window and handshake qualification
    always_comb begin
        listen_o = !active_i || last_i;
        ready_o  = listen_o && req_i && room_i;
        take_o   = ready_o && in_valid_i;
    end
endmodule

// File: rtl/txb_shifter.sv
// Byte shift engine: on load it raises the strobe for one cycle with
// the MSB on the line, then walks down to bit 0. When idle it holds the
// last driven bit. Assumes load_i is only high while listening.
module txb_shifter #(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = txb_pkg::cnt_bits(BYTE_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              active_o,
    output logic              last_o,
    output logic              bs_o,
    output logic              sd_o
);
    import txb_pkg::*;

    localparam logic [IDX_W-1:0] TopIdx = IDX_W'(BYTE_W - 1);

    txb_phase_e        phase_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;

    // Phase, shift register, bit index and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            shreg_q <= '0;
            idx_q   <= '0;
            bs_o    <= 1'b0;
        end else if (load_i) begin
            phase_q <= PH_SHIFT;
            shreg_q <= data_i;
            idx_q   <= TopIdx;
            bs_o    <= 1'b1;
        end else if (phase_q == PH_SHIFT && idx_q != '0) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
            idx_q   <= idx_q - 1'b1;
            bs_o    <= 1'b0;
        end else begin
            phase_q <= PH_IDLE;
            bs_o    <= 1'b0;
        end
    end

    // Line and status views of the engine
    always_comb begin
        sd_o     = shreg_q[BYTE_W-1];
        active_o = (phase_q == PH_SHIFT);
        last_o   = (phase_q == PH_SHIFT) && (idx_q == '0);
    end
endmodule

// File: rtl/txb_serial_tx.sv
// Top of the request-gated byte-strobe serial transmitter. Ties the
// frame budget, the request gate and the shift engine together.
// Assumes clk is the serial clock shared with the remote consumer.
module txb_serial_tx #(
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 255,
    parameter int CNT_W     = txb_pkg::cnt_bits(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic [CNT_W-1:0]  frame_len_i,
    input  logic [BYTE_W-1:0] in_data_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic              req_i,
    output logic              frm_o,
    output logic              bs_o,
    output logic              sd_o,
    output logic              viol_o
);
    logic active_w;
    logic last_w;
    logic listen_w;
    logic take_w;
    logic room_w;

    txb_frame_budget #(
        .MAX_BYTES (MAX_BYTES),
        .CNT_W     (CNT_W)
    ) u_budget (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start_i),
        .frame_len_i   (frame_len_i),
        .take_i        (take_w),
        .listen_i      (listen_w),
        .req_i         (req_i),
        .room_o        (room_w),
        .frm_o         (frm_o),
        .viol_o        (viol_o)
    );

    txb_req_gate u_gate (
        .active_i   (active_w),
        .last_i     (last_w),
        .req_i      (req_i),
        .room_i     (room_w),
        .in_valid_i (in_valid_i),
        .listen_o   (listen_w),
        .ready_o    (in_ready_o),
        .take_o     (take_w)
    );

    txb_shifter #(
        .BYTE_W (BYTE_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (take_w),
        .data_i   (in_data_i),
        .active_o (active_w),
        .last_o   (last_w),
        .bs_o     (bs_o),
        .sd_o     (sd_o)
    );
endmodule

// File: rtl/txb_checker.sv
// Protocol checker for txb_serial_tx, attached by bind. Tracks strobe
// spacing and the frame budget from the ports only.
module txb_checker #(
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 255,
    parameter int CNT_W     = txb_pkg::cnt_bits(MAX_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start_i,
    input logic [CNT_W-1:0]  frame_len_i,
    input logic              in_valid_i,
    input logic              in_ready_o,
    input logic              req_i,
    input logic              frm_o,
    input logic              bs_o,
    input logic              sd_o,
    input logic              viol_o
);
    localparam int SW = txb_pkg::cnt_bits(BYTE_W);
    localparam logic [SW-1:0] SatVal = SW'(BYTE_W);
    localparam logic [CNT_W-1:0] LenCap = CNT_W'(MAX_BYTES);

    logic [SW-1:0]    since_q;
    logic             c_open_q;
    logic [CNT_W-1:0] c_len_q;
    logic [CNT_W-1:0] c_sent_q;

    // Cycles since the last strobe, saturating at BYTE_W
    always_ff @(posedge clk) begin
        if (!rst_n)              since_q <= SatVal;
        else if (bs_o)           since_q <= SW'(1);
        else if (since_q < SatVal) since_q <= since_q + 1'b1;
    end

    // Strobes seen in the current frame versus its budget
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_open_q <= 1'b0;
            c_len_q  <= '0;
            c_sent_q <= '0;
        end else if (frame_start_i) begin
            c_open_q <= 1'b1;
            c_len_q  <= (frame_len_i > LenCap) ? LenCap : frame_len_i;
            c_sent_q <= '0;
        end else if (bs_o) begin
            c_sent_q <= c_sent_q + 1'b1;
        end
    end

    AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> frm_o); // R1
    AST_STROBE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bs_o |-> ($past(req_i) && $past(in_valid_i) && $past(in_ready_o))); // R2
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bs_o |=> !bs_o); // R3
    AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        bs_o |-> (since_q >= SatVal)); // R4
    AST_DEAF_MIDBYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (bs_o || (since_q >= SW'(1) && since_q <= SW'(BYTE_W - 2))) |-> !in_ready_o); // R6
    AST_BUDGET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        bs_o |-> (c_open_q && c_sent_q < c_len_q)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bs_o && since_q >= SatVal) |-> $stable(sd_o)); // R8
    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_o && !frame_start_i) |=> viol_o); // R9
endmodule

bind txb_serial_tx txb_checker #(
    .BYTE_W    (BYTE_W),
    .MAX_BYTES (MAX_BYTES),
    .CNT_W     (CNT_W)
) u_txb_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start_i),
    .frame_len_i   (frame_len_i),
    .in_valid_i    (in_valid_i),
    .in_ready_o    (in_ready_o),
    .req_i         (req_i),
    .frm_o         (frm_o),
    .bs_o          (bs_o),
    .sd_o          (sd_o),
    .viol_o        (viol_o)
);

// File: tb/txb_serial_tx_bench.sv
`timescale 1ns/1ps
module txb_serial_tx_bench;
    localparam int BW   = 8;
    localparam int MAXB = 15;
    localparam int CW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic [CW-1:0] frame_len = '0;
    logic [BW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          req = 1'b0;
    logic          frm, bs, sd, viol;

    int checks = 0;
    int failures = 0;
    int nstrobe = 0;
    bit done = 0;

    logic [BW-1:0] src_q[$];
    logic [BW-1:0] exp_q[$];

    always #4 clk = ~clk;

    txb_serial_tx #(.BYTE_W(BW), .MAX_BYTES(MAXB), .CNT_W(CW)) u_txb_serial_tx (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start), .frame_len_i(frame_len),
        .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
        .req_i(req), .frm_o(frm), .bs_o(bs), .sd_o(sd), .viol_o(viol)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic refresh();
        in_valid = (src_q.size() > 0);
        in_data  = (src_q.size() > 0) ? src_q[0] : '0;
    endtask

    // Driver: offer a byte and record it as expected on the line
    task automatic offer(input logic [BW-1:0] b);
        src_q.push_back(b);
        exp_q.push_back(b);
        refresh();
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: capture strobed bytes MSB first and compare in order
    int            cap_left = 0;
    logic [BW-1:0] cap_val;
    logic [BW-1:0] cap_exp;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cap_left > 0) begin
                cap_val = {cap_val[BW-2:0], sd};
                cap_left--;
                if (cap_left == 0) chk("R3 byte bits", cap_val, cap_exp);
            end
            if (bs) begin
                nstrobe++;
                chk("R3 strobe inside byte", cap_left, 0);
                if (exp_q.size() == 0) begin
                    chk("R7 unexpected strobe", 1, 0);
                    cap_exp = '0;
                end else begin
                    cap_exp = exp_q.pop_front();
                end
                if (src_q.size() > 0) void'(src_q.pop_front());
                refresh();
                cap_val  = {{(BW-1){1'b0}}, sd};
                cap_left = BW - 1;
            end
        end
    end

    initial begin
        int n0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R10: reset state
        chk("R10 bs", bs, 0);
        chk("R10 frm", frm, 0);
        chk("R10 viol", viol, 0);
        chk("R10 sd", sd, 0);
        chk("R10 in_ready", in_ready, 0);

        // R9 / R7: request before any frame
        req = 1'b1;
        tick(1);
        chk("R7 ready without frame", in_ready, 0);
        chk("R9 viol before frame", viol, 1);
        chk("R7 no strobe without frame", bs, 0);
        req = 1'b0;

        // R1: open a frame of 4 bytes
        frame_start = 1'b1; frame_len = 4'd4;
        tick(1);
        frame_start = 1'b0;
        chk("R1 frame pulse", frm, 1);
        chk("R1 viol cleared", viol, 0);
        tick(1);
        chk("R1 pulse one cycle", frm, 0);

        // R2 / R4 / R6 / R5: back-to-back, ignored request, one-cycle wait
        offer(8'hA5); offer(8'h3C); offer(8'h81);
        req = 1'b1;
        tick(1);
        chk("R2 strobe latency", bs, 1);
        tick(3);
        chk("R6 ready low mid byte", in_ready, 0);
        tick(5);
        chk("R4 back-to-back strobe", bs, 1);
        req = 1'b0;                      // dropped mid byte: byte must complete
        tick(8);
        chk("R5 no strobe without request", bs, 0);
        req = 1'b1;
        tick(1);
        chk("R5 strobe after one wait cycle", bs, 1);
        req = 1'b0;
        tick(8);
        chk("R8 idle no strobe", bs, 0);
        for (int i = 0; i < 4; i++) begin
            tick(1);
            chk("R8 idle line holds bit0", sd, 1);
        end

        // R5: request without data waits, then data goes at once
        n0 = nstrobe;
        req = 1'b1;
        tick(10);
        chk("R5 no strobe without data", nstrobe, n0);
        chk("R9 no viol while budget left", viol, 0);
        offer(8'h5A);
        tick(1);
        chk("R5 strobe once data offered", bs, 1);
        tick(8);
        chk("R7 budget of 4 reached", bs, 0);
        tick(1);
        chk("R9 viol after budget", viol, 1);
        chk("R7 ready low after budget", in_ready, 0);
        n0 = nstrobe;
        offer(8'hFF);
        tick(3);
        chk("R7 no strobe after budget", nstrobe, n0);

        // R1 / R4 / R7: frame of 2 bytes back to back
        req = 1'b0;
        tick(1);
        frame_start = 1'b1; frame_len = 4'd2;
        tick(1);
        frame_start = 1'b0;
        chk("R1 second frame pulse", frm, 1);
        chk("R1 viol cleared again", viol, 0);
        req = 1'b1;
        tick(1);
        chk("R2 first byte of frame", bs, 1);
        offer(8'h00);
        tick(8);
        chk("R4 second byte back to back", bs, 1);
        tick(8);
        chk("R7 budget of 2 reached", bs, 0);
        tick(1);
        chk("R9 viol on exhausted frame", viol, 1);

        // R7: empty frame
        req = 1'b0;
        frame_start = 1'b1; frame_len = 4'd0;
        tick(1);
        frame_start = 1'b0;
        n0 = nstrobe;
        offer(8'h77);
        req = 1'b1;
        tick(3);
        chk("R7 zero budget no strobe", nstrobe, n0);
        chk("R7 zero budget ready low", in_ready, 0);
        chk("R9 viol on zero budget", viol, 1);
        req = 1'b0;
        tick(10);
        chk("R7 only unsent byte left", exp_q.size(), 1);
        chk("R3 no capture pending", cap_left, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule